// File: doc/BRIEF.md
# Ethernet Frame Transmit Encapsulator

This block sits between a MAC-level source of frame bodies and the byte-wide transmit path. The source hands over each frame as a byte stream that starts with the destination address and runs through the type field and the payload. It marks the first byte with a start flag and the final byte with an end flag. The block wraps each body for the wire. It puts the preamble and the start delimiter in front and passes the body bytes through unchanged. It appends zero bytes when the body is too short, then adds a four-byte CRC-32 check sequence that it computes as the bytes go by.

The input has a valid/ready handshake. Ready stays low while the block produces bytes of its own (preamble, delimiter, padding, check sequence) and during the forced idle time after each frame. The output has no handshake: one byte leaves per cycle in which `out_valid` is high. An over-long body is cut short at the maximum size and flagged instead of being closed with a check sequence.

Top module: `eth_tx_framer`

## Requirements
- R1: After reset, `out_valid`, `out_last` and `out_err` are low. While no start flag is presented, `in_ready` is high.
- R2: Each frame on the output begins with seven bytes of value 0x55 and then one byte 0xD5, with bits sent least significant first. `in_ready` stays low while these eight bytes are produced.
- R3: Each body byte accepted on the input appears on the output once, in arrival order, directly after the 0xD5 byte.
- R4: A body shorter than 60 bytes is followed by zero bytes until 60 body bytes have been sent. A body of 60 bytes or more gets no padding.
- R5: Four check bytes follow the body and padding. They carry a CRC-32 with reflected polynomial 0xEDB88320 (0x04C11DB7 bit-reversed) and a register seeded with all ones. The CRC covers body and padding bytes, is complemented at the end, and is sent least significant byte first.
- R6: `out_last` is high on exactly one byte per frame: the final check byte of a normal frame.
- R7: After the last byte of a frame, `out_valid` stays low for at least 12 cycles. If the next frame is already waiting, it stays low for exactly 12 cycles.
- R8: If a body reaches 1514 bytes without its end flag, byte 1514 is sent with `out_last` and `out_err` high and no check sequence follows. The remaining input up to the end flag is accepted and dropped, and the idle gap of R7 follows.
- R9: A body of exactly 1514 bytes ending with its end flag is sent normally with its check sequence, and `out_err` stays low.
- R10: Bytes presented while idle without a start flag are accepted and discarded, and they produce no output.
- R11: Cycles without input valid in the middle of a body leave `out_valid` low in the matching output cycles. The frame content does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input body byte |
| in_sof | input | 1 | Marks the first byte of a body |
| in_eof | input | 1 | Marks the last byte of a body |
| in_ready | output | 1 | Block accepts the input byte this cycle |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte on the wire |
| out_last | output | 1 | Final byte of the frame |
| out_err | output | 1 | Frame was truncated; no valid check sequence |

## Verification
Frame bodies of 14, 20, 59, 60, 61 and 100 bytes are run, some with input stalls. The lengths just below, at and above 60 separate the padding decision from the pass-through, and bodies with different fill patterns separate the CRC arithmetic from the byte order of the check field. Two frames sent back to back measure the exact idle gap. A 1520-byte body and a 1514-byte body tell the truncation path apart from the largest legal frame. Stray bytes without a start flag confirm that nothing leaks onto the wire while the block is idle.

// File: rtl/eth_fr_pkg.sv
`timescale 1ns/1ps
package eth_fr_pkg;

    localparam logic [7:0]  PRE_BYTE      = 8'h55;
    localparam logic [7:0]  SFD_BYTE      = 8'hD5;
    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
    localparam logic [31:0] CRC_SEED      = 32'hFFFFFFFF;

    typedef enum logic [2:0] {
        S_IDLE, S_PRE, S_BODY, S_PAD, S_FCS, S_DROP, S_GAP
    } seq_st_e;

    typedef enum logic [2:0] {
        K_NONE, K_PRE, K_SFD, K_DATA, K_PAD, K_FCS
    } emit_kind_e;

    typedef struct packed {
        emit_kind_e kind;
        logic [1:0] fidx;
        logic       last;
        logic       err;
    } emit_s;

    // One byte of the reflected CRC-32, LSB of the byte first.
    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c ^ {24'd0, d};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/eth_fcs_acc.sv
`timescale 1ns/1ps
module eth_fcs_acc import eth_fr_pkg::*; (
    input  logic        clk,
    input  logic        rst,
    input  logic        init,
    input  logic        upd,
    input  logic [7:0]  data,
    output logic [31:0] crc
);

    always_ff @(posedge clk) begin
        if (rst || init) begin
            crc <= CRC_SEED;
        end else if (upd) begin
            crc <= crc_step(crc, data);
        end
    end

    // R5: every frame's CRC starts from the all-ones seed
    assert_crc_seed_R5: assert property (@(posedge clk) disable iff (rst)
        init |=> (crc == CRC_SEED));

endmodule

// File: rtl/eth_fr_seq.sv
`timescale 1ns/1ps
module eth_fr_seq import eth_fr_pkg::*; #(
    parameter int PRE_LEN  = 7,
    parameter int MIN_BODY = 60,
    parameter int MAX_BODY = 1514,
    parameter int GAP_LEN  = 12
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  logic  in_sof,
    input  logic  in_eof,
    output logic  in_ready,
    output emit_s emit
);

    localparam int PCW = $clog2(PRE_LEN + 1);
    localparam int BCW = $clog2(MAX_BODY + 1);
    localparam int GCW = $clog2(GAP_LEN + 1);

    seq_st_e        st, st_n;
    logic [PCW-1:0] pcnt, pcnt_n;
    logic [BCW-1:0] bcnt, bcnt_n, bcnt_inc;
    logic [1:0]     fidx, fidx_n;
    logic [GCW-1:0] gcnt, gcnt_n;

    assign bcnt_inc = bcnt + 1'b1;

    always_comb begin
        st_n     = st;
        pcnt_n   = pcnt;
        bcnt_n   = bcnt;
        fidx_n   = fidx;
        gcnt_n   = gcnt;
        in_ready = 1'b0;
        emit     = '{kind: K_NONE, fidx: 2'd0, last: 1'b0, err: 1'b0};
        unique case (st)
            S_IDLE: begin
                in_ready = !in_sof;
                if (in_valid && in_sof) begin
                    emit.kind = K_PRE;
                    pcnt_n    = PCW'(1);
                    st_n      = S_PRE;
                end
            end
            S_PRE: begin
                if (pcnt == PCW'(PRE_LEN)) begin
                    emit.kind = K_SFD;
                    bcnt_n    = '0;
                    st_n      = S_BODY;
                end else begin
                    emit.kind = K_PRE;
                    pcnt_n    = pcnt + 1'b1;
                end
            end
            S_BODY: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    emit.kind = K_DATA;
                    bcnt_n    = bcnt_inc;
                    if (in_eof) begin
                        fidx_n = 2'd0;
                        st_n   = (bcnt_inc < BCW'(MIN_BODY)) ? S_PAD : S_FCS;
                    end else if (bcnt_inc == BCW'(MAX_BODY)) begin
                        emit.last = 1'b1;
                        emit.err  = 1'b1;
                        st_n      = S_DROP;
                    end
                end
            end
            S_PAD: begin
                emit.kind = K_PAD;
                bcnt_n    = bcnt_inc;
                if (bcnt_inc == BCW'(MIN_BODY)) begin
                    st_n = S_FCS;
                end
            end
            S_FCS: begin
                emit.kind = K_FCS;
                emit.fidx = fidx;
                fidx_n    = fidx + 1'b1;
                if (fidx == 2'd3) begin
                    emit.last = 1'b1;
                    gcnt_n    = '0;
                    st_n      = S_GAP;
                end
            end
            S_DROP: begin
                in_ready = 1'b1;
                if (in_valid && in_eof) begin
                    gcnt_n = '0;
                    st_n   = S_GAP;
                end
            end
            S_GAP: begin
                gcnt_n = gcnt + 1'b1;
                if (gcnt == GCW'(GAP_LEN - 1)) begin
                    st_n = S_IDLE;
                end
            end
            default: st_n = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= S_IDLE;
            pcnt <= '0;
            bcnt <= '0;
            fidx <= '0;
            gcnt <= '0;
        end else begin
            st   <= st_n;
            pcnt <= pcnt_n;
            bcnt <= bcnt_n;
            fidx <= fidx_n;
            gcnt <= gcnt_n;
        end
    end

    // R8: the body counter never runs past the maximum while bytes still pass
    assert_body_bound_R8: assert property (@(posedge clk) disable iff (rst)
        (st == S_BODY) |-> (bcnt < BCW'(MAX_BODY)));

    // R4: the pad phase only runs while the body is still short
    assert_pad_short_R4: assert property (@(posedge clk) disable iff (rst)
        (st == S_PAD) |-> (bcnt < BCW'(MIN_BODY)));

endmodule

// File: rtl/eth_tx_framer.sv
`timescale 1ns/1ps
module eth_tx_framer import eth_fr_pkg::*; #(
    parameter int PRE_LEN  = 7,
    parameter int MIN_BODY = 60,
    parameter int MAX_BODY = 1514,
    parameter int GAP_LEN  = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_sof,
    input  logic       in_eof,
    output logic       in_ready,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_last,
    output logic       out_err
);

    localparam int FCS_LEN = 4;
    localparam int RUNW    = $clog2(PRE_LEN + 1 + MAX_BODY + FCS_LEN + 1);
    localparam int GCW     = $clog2(GAP_LEN + 1);

    emit_s       emit;
    logic [31:0] crc;
    logic [31:0] crc_inv;
    logic [7:0]  byte_sel;

    eth_fr_seq #(
        .PRE_LEN (PRE_LEN),
        .MIN_BODY(MIN_BODY),
        .MAX_BODY(MAX_BODY),
        .GAP_LEN (GAP_LEN)
    ) seq_i (
        .clk     (clk),
        .rst     (rst),
        .in_valid(in_valid),
        .in_sof  (in_sof),
        .in_eof  (in_eof),
        .in_ready(in_ready),
        .emit    (emit)
    );

    eth_fcs_acc fcs_i (
        .clk (clk),
        .rst (rst),
        .init(emit.kind == K_PRE),
        .upd ((emit.kind == K_DATA) || (emit.kind == K_PAD)),
        .data(byte_sel),
        .crc (crc)
    );

    assign crc_inv = ~crc;

    always_comb begin
        unique case (emit.kind)
            K_PRE:   byte_sel = PRE_BYTE;
            K_SFD:   byte_sel = SFD_BYTE;
            K_DATA:  byte_sel = in_data;
            K_FCS:   byte_sel = crc_inv[8*emit.fidx +: 8];
            default: byte_sel = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= 8'h00;
            out_last  <= 1'b0;
            out_err   <= 1'b0;
        end else begin
            out_valid <= (emit.kind != K_NONE);
            out_data  <= byte_sel;
            out_last  <= emit.last;
            out_err   <= emit.err;
        end
    end

    // Output-side observers for the assertions below
    logic [RUNW-1:0] bytes_run;
    logic            gap_pend;
    logic [GCW-1:0]  gap_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            bytes_run <= '0;
            gap_pend  <= 1'b0;
            gap_cnt   <= '0;
        end else begin
            if (out_valid) begin
                bytes_run <= out_last ? '0 : bytes_run + 1'b1;
            end
            if (out_valid && out_last) begin
                gap_pend <= 1'b1;
                gap_cnt  <= '0;
            end else if (out_valid) begin
                gap_pend <= 1'b0;
            end else if (gap_pend && (gap_cnt != GCW'(GAP_LEN))) begin
                gap_cnt <= gap_cnt + 1'b1;
            end
        end
    end

    assert_preamble_R2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (bytes_run < RUNW'(PRE_LEN))) |-> (out_data == PRE_BYTE));

    assert_sfd_R2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (bytes_run == RUNW'(PRE_LEN))) |-> (out_data == SFD_BYTE));

    assert_min_len_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_last && !out_err)
            |-> (bytes_run >= RUNW'(PRE_LEN + 1 + MIN_BODY + FCS_LEN - 1)));

    assert_last_valid_R6: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);

    assert_idle_gap_R7: assert property (@(posedge clk) disable iff (rst)
        (gap_pend && out_valid) |-> (gap_cnt >= GCW'(GAP_LEN)));

    assert_err_on_last_R8: assert property (@(posedge clk) disable iff (rst)
        out_err |-> (out_last && out_valid));

endmodule

// File: tb/eth_tx_framer_tb.sv
`timescale 1ns/1ps
module eth_tx_framer_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_sof = 1'b0;
    logic       in_eof = 1'b0;
    logic       in_ready;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_last;
    logic       out_err;

    always #2.5 clk = ~clk;

    eth_tx_framer dut_i (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
        .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .out_err(out_err)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Captured output stream
    logic [7:0] cap [0:2047];
    int  cap_n = 0;
    int  got_last = 0;
    bit  last_err = 0;
    int  last_cnt_err = 0;
    int  idle_run = 0;
    bit  after_last = 0;
    int  min_gap = 1000;

    always @(negedge clk) begin
        if (rst) begin
            idle_run   = 0;
            after_last = 0;
        end else if (out_valid) begin
            if (cap_n < 2048) cap[cap_n] = out_data;
            cap_n++;
            if (after_last && idle_run < min_gap) min_gap = idle_run;
            after_last = out_last;
            idle_run   = 0;
            if (out_last) begin
                got_last++;
                last_err = out_err;
            end
            if (out_err && !out_last) last_cnt_err++;
        end else begin
            idle_run++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] gen_byte(input int seed, input int i);
        return 8'((seed * 29 + i * 7 + (i >> 4)) & 255);
    endfunction

    function automatic logic [31:0] ref_crc(input logic [31:0] c0, input logic [7:0] d);
        logic [31:0] c;
        logic fb;
        c = c0;
        for (int k = 0; k < 8; k++) begin
            fb = c[0] ^ d[k];
            c  = {1'b0, c[31:1]};
            if (fb) c = c ^ 32'hEDB88320;
        end
        return c;
    endfunction

    task automatic push(input logic [7:0] d, input bit s, input bit e);
        bit r;
        r = 0;
        while (!r) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = d; in_sof = s; in_eof = e;
            #1;
            r = in_ready;
            @(posedge clk);
        end
    endtask

    task automatic idle_in();
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    endtask

    task automatic send_body(input int len, input int seed, input bit stall, input bit with_eof);
        for (int i = 0; i < len; i++) begin
            if (stall && (i % 5 == 3)) idle_in();
            push(gen_byte(seed, i), i == 0, with_eof && (i == len - 1));
        end
        idle_in();
    endtask

    task automatic wait_last(input int target);
        while (got_last < target) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // Sends one body and compares the whole frame on the wire
    task automatic run_frame(input int len, input int seed, input bit stall);
        int base, plen, total, m_pre, m_body, m_pad, m_fcs;
        logic [31:0] c;
        logic [7:0] e;
        cap_n = 0;
        base  = got_last;
        send_body(len, seed, stall, 1'b1);
        wait_last(base + 1);
        plen  = (len < 60) ? 60 : len;
        total = 8 + plen + 4;
        c = 32'hFFFFFFFF;
        m_pre = 0; m_body = 0; m_pad = 0; m_fcs = 0;
        for (int i = 0; i < 8; i++) begin
            e = (i < 7) ? 8'h55 : 8'hD5;
            if (cap[i] !== e) m_pre++;
        end
        for (int i = 0; i < plen; i++) begin
            e = (i < len) ? gen_byte(seed, i) : 8'h00;
            c = ref_crc(c, e);
            if (cap[8 + i] !== e) begin
                if (i < len) m_body++; else m_pad++;
            end
        end
        c = ~c;
        for (int j = 0; j < 4; j++) begin
            if (cap[8 + plen + j] !== c[8*j +: 8]) m_fcs++;
        end
        chk(cap_n == total, "R4", $sformatf("frame length, body %0d", len), cap_n, total);
        chk(m_pre == 0, "R2", "preamble/delimiter mismatches", m_pre, 0);
        chk(m_body == 0, stall ? "R11" : "R3", "body mismatches", m_body, 0);
        chk(m_pad == 0, "R4", "pad byte mismatches", m_pad, 0);
        chk(m_fcs == 0, "R5", "check byte mismatches", m_fcs, 0);
        chk(last_err == 1'b0, len == 1514 ? "R9" : "R6", "out_err on final byte", int'(last_err), 0);
    endtask

    // {body length, seed, stall flag}
    localparam logic [31:0] VECS [6] = '{
        {16'd14,  8'd3,  8'd0},
        {16'd20,  8'd17, 8'd1},
        {16'd59,  8'd5,  8'd0},
        {16'd60,  8'd9,  8'd1},
        {16'd61,  8'd11, 8'd0},
        {16'd100, 8'd23, 8'd1}
    };

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int base;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        // R1: reset state
        chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
        chk(out_last == 1'b0 && out_err == 1'b0, "R1", "last/err after reset",
            int'({out_last, out_err}), 0);
        chk(in_ready == 1'b1, "R1", "in_ready while idle", int'(in_ready), 1);

        // Table of bodies, one loop
        for (int v = 0; v < 6; v++) begin
            run_frame(int'(VECS[v][31:16]), int'(VECS[v][15:8]), VECS[v][0]);
        end
        chk(min_gap >= 12, "R7", "shortest idle gap", min_gap, 12);

        // R10: stray bytes while idle
        cap_n = 0;
        push(8'hA1, 1'b0, 1'b0);
        push(8'hB2, 1'b0, 1'b1);
        push(8'hC3, 1'b0, 1'b0);
        idle_in();
        repeat (20) @(negedge clk);
        chk(cap_n == 0, "R10", "bytes output for stray input", cap_n, 0);
        run_frame(30, 41, 1'b0);

        // R7: two frames back to back
        cap_n   = 0;
        min_gap = 1000;
        base    = got_last;
        send_body(20, 50, 1'b0, 1'b1);
        send_body(20, 51, 1'b0, 1'b1);
        wait_last(base + 2);
        chk(min_gap == 12, "R7", "gap with next frame waiting", min_gap, 12);
        chk(cap_n == 2 * 72, "R7", "bytes for two frames", cap_n, 144);

        // R8: truncation of an over-long body
        begin
            int mism;
            cap_n = 0;
            base  = got_last;
            send_body(1520, 61, 1'b0, 1'b1);
            wait_last(base + 1);
            repeat (30) @(negedge clk);
            chk(cap_n == 8 + 1514, "R8", "bytes sent for over-long body", cap_n, 1522);
            chk(last_err == 1'b1, "R8", "out_err on truncated last byte", int'(last_err), 1);
            chk(got_last == base + 1, "R8", "frame ends after truncation", got_last - base, 1);
            mism = 0;
            for (int i = 0; i < 1514; i++) begin
                if (cap[8 + i] !== gen_byte(61, i)) mism++;
            end
            chk(mism == 0, "R8", "truncated body mismatches", mism, 0);
            chk(last_cnt_err == 0, "R8", "out_err without out_last", last_cnt_err, 0);
        end
        run_frame(64, 77, 1'b0);

        // R9: largest legal body
        run_frame(1514, 88, 1'b0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule